// File: doc/BRIEF.md
# Scan Compression Test Wrapper

This block sits between a small number of external scan channels and a larger set of internal scan chains. When compression is switched on, each scan-in channel fans out to several internal chains. The fanout is either a direct broadcast or an XOR spreading network. On the output side, the chain tails are reduced to the scan-out channels by an XOR tree, or they are folded into a multiple-input signature register (MISR), which is then unloaded serially. A mask register, clocked separately, can force selected chain outputs to zero before they are compacted, so a chain that carries unknown values does not spoil the result.

Compression is enabled by two signals together: a compression enable, which may be shared with a functional pin, and a dedicated master enable. When compression is off, the wrapper joins the internal chains end to end into plain full-scan chains, one per channel. The chain flops themselves live outside the block. The wrapper drives each chain's serial input and observes each chain's last flop. The chains move data only while the shift enable is high.

With the default parameters there are two channels and a ratio of two, which gives four internal chains. The MISR is 8 bits wide.

Top module: `scan_comp_wrap`

## Requirements
- R1: While `rst` is high at a `clk` edge, `scan_out`, the MISR state and the previous-shift flag clear to zero. While `rst` is high at a `mask_clk` edge, both mask stages clear to zero.
- R2: Compression is active only when `comp_en` and `master_en` are both 1. With either one at 0, the block behaves exactly as the bypass of R3.
- R3: In bypass, chain k = g*NCH + l (lane l, group g) is routed as follows. For g = 0 it receives `scan_in[l]`. For g > 0 it receives `chain_so[k-NCH]`. One clock after any cycle, `scan_out[l]` equals that cycle's `chain_so[(RATIO-1)*NCH + l]`.
- R4: With compression active and `spread_sel` = 0, every chain k receives `scan_in[k mod NCH]`.
- R5: With compression active and `spread_sel` = 1, group-0 chains receive `scan_in[l]`. A chain in group g > 0 receives `scan_in[l] ^ scan_in[(l + 1 + ((g-1) mod (NCH-1))) mod NCH]`.
- R6: With compression active and `misr_sel` = 0, one clock after any cycle `scan_out[l]` is the XOR, over all groups g, of that cycle's masked `chain_so[g*NCH + l]`.
- R7: A 1 in mask bit k replaces `chain_so[k]` with 0 before XOR compaction and before MISR folding. The mask has no effect in bypass.
- R8: On a `mask_clk` rising edge with `mask_en` = 1, the mask shift stage takes `mask_si` into bit 0 and moves the other bits up, so the first bit shifted in ends at chain NC-1 after NC pulses. The applied mask copies the shift stage only on a `mask_clk` edge where `mask_load` = 1, and holds otherwise.
- R9: With compression active, `misr_sel` = 1, `shift_en` = 1 and `misr_unload` = 0, each `clk` edge updates the MISR. The new state is step(prev) XOR fold. Here step(s) = (s << 1) XOR (s[MW-1] ? POLY : 0), with POLY = 8'h1D by default. fold bit i is the XOR of the masked chain outputs k with k mod MW = i. In this mode `scan_out` is all zeros one clock later.
- R10: If `shift_en` was 0 in the previous `clk` cycle, the R9 update uses 0 in place of prev. Each shift window therefore starts a fresh signature.
- R11: With compression active, `misr_sel` = 1 and `misr_unload` = 1, each `clk` edge shifts the MISR left with 0 fill. `scan_out[0]` takes the old top bit on the same edge, and the other channels are 0. Unload takes priority over accumulation.
- R12: With `shift_en` = 0 and `misr_unload` = 0, the MISR holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Scan shift enable for chains and MISR |
| comp_en | input | 1 | Compression enable (may be a shared pin) |
| master_en | input | 1 | Dedicated master control, ANDed with comp_en |
| spread_sel | input | 1 | 1 selects the XOR spreader, 0 selects broadcast |
| misr_sel | input | 1 | 1 selects MISR compaction, 0 selects the XOR tree |
| misr_unload | input | 1 | Serially unload the MISR on scan_out[0] |
| scan_in | input | NCH | External scan-in channels |
| scan_out | output | NCH | External scan-out channels (registered) |
| chain_si | output | NC | Serial input of each internal chain |
| chain_so | input | NC | Last flop of each internal chain |
| mask_clk | input | 1 | Clock for the mask register |
| mask_en | input | 1 | Shift enable of the mask shift stage |
| mask_load | input | 1 | Copy the shift stage into the applied mask |
| mask_si | input | 1 | Serial mask data |

## Verification
The bound checker watches several rules on every clock. It checks the bypass head-of-chain routing and the effect of the master gate. It checks broadcast fanout on the second group of chains. It checks that scan-out stays silent while the MISR accumulates and that the top bit emerges one clock into an unload. It also checks that the MISR holds outside shift, and that the applied mask moves only on a load edge. Other properties need many cycles and a model of the chains to show. These are the exact XOR spreader values, XOR-tree results under different masks, the fresh start of each shift window, and the full serial signature. The bench covers them with cycle-by-cycle reference models run over random scan data.

// File: rtl/scw_pkg.sv
package scw_pkg;
  typedef enum logic [1:0] {
    OUT_BYPASS = 2'd0,
    OUT_XOR    = 2'd1,
    OUT_MISR   = 2'd2
  } out_mode_e;
endpackage

// File: rtl/scw_decomp.sv
module scw_decomp #(
  parameter int NCH   = 2,
  parameter int RATIO = 2,
  localparam int NC   = NCH * RATIO
) (
  input  logic           active,
  input  logic           spread_sel,
  input  logic [NCH-1:0] scan_in,
  input  logic [NC-1:0]  chain_so,
  output logic [NC-1:0]  chain_si
);
  for (genvar k = 0; k < NC; k++) begin : g_chain
    localparam int LANE  = k % NCH;
    localparam int GROUP = k / NCH;
    logic byp_bit;
    logic spr_bit;
    if (GROUP == 0) begin : g_head
      assign byp_bit = scan_in[LANE];
      assign spr_bit = scan_in[LANE];
    end else begin : g_body
      localparam int PARTNER = (LANE + 1 + ((GROUP - 1) % (NCH - 1))) % NCH;
      assign byp_bit = chain_so[k-NCH];
      assign spr_bit = scan_in[LANE] ^ scan_in[PARTNER];
    end
    always_comb begin
      if (!active)         chain_si[k] = byp_bit;
      else if (spread_sel) chain_si[k] = spr_bit;
      else                 chain_si[k] = scan_in[LANE];
    end
  end
endmodule

// File: rtl/scw_mask.sv
module scw_mask #(
  parameter int NC = 4
) (
  input  logic          mask_clk,
  input  logic          rst,
  input  logic          mask_en,
  input  logic          mask_load,
  input  logic          mask_si,
  output logic [NC-1:0] mask_q
);
  logic [NC-1:0] shift_q;

  always_ff @(posedge mask_clk) begin
    if (rst) begin
      shift_q <= '0;
      mask_q  <= '0;
    end else begin
      if (mask_en)   shift_q <= {shift_q[NC-2:0], mask_si};
      if (mask_load) mask_q  <= shift_q;
    end
  end
endmodule

// File: rtl/scw_compact.sv
module scw_compact #(
  parameter int NCH   = 2,
  parameter int RATIO = 2,
  localparam int NC   = NCH * RATIO
) (
  input  logic [NC-1:0]  chain_so,
  input  logic [NC-1:0]  mask_q,
  output logic [NC-1:0]  masked,
  output logic [NCH-1:0] xor_out
);
  assign masked = chain_so & ~mask_q;

  for (genvar l = 0; l < NCH; l++) begin : g_lane
    always_comb begin
      xor_out[l] = 1'b0;
      for (int g = 0; g < RATIO; g++) xor_out[l] ^= masked[g*NCH + l];
    end
  end
endmodule

// File: rtl/scw_misr.sv
module scw_misr #(
  parameter int          NC   = 4,
  parameter int          MW   = 8,
  parameter logic [MW-1:0] POLY = 8'h1D
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          shift_en,
  input  logic          unload,
  input  logic [NC-1:0] din,
  output logic [MW-1:0] state
);
  logic          se_prev;
  logic [MW-1:0] fold;
  logic [MW-1:0] stepped;

  always_comb begin
    fold = '0;
    for (int k = 0; k < NC; k++) fold[k % MW] ^= din[k];
  end

  assign stepped = {state[MW-2:0], 1'b0} ^ (state[MW-1] ? POLY : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= '0;
      se_prev <= 1'b0;
    end else begin
      se_prev <= shift_en;
      if (run && unload)        state <= {state[MW-2:0], 1'b0};
      else if (run && shift_en) state <= (se_prev ? stepped : '0) ^ fold;
    end
  end
endmodule

// File: rtl/scan_comp_wrap.sv
module scan_comp_wrap #(
  parameter int            NCH   = 2,
  parameter int            RATIO = 2,
  parameter int            MW    = 8,
  parameter logic [MW-1:0] POLY  = 8'h1D,
  localparam int           NC    = NCH * RATIO
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic           comp_en,
  input  logic           master_en,
  input  logic           spread_sel,
  input  logic           misr_sel,
  input  logic           misr_unload,
  input  logic [NCH-1:0] scan_in,
  output logic [NCH-1:0] scan_out,
  output logic [NC-1:0]  chain_si,
  input  logic [NC-1:0]  chain_so,
  input  logic           mask_clk,
  input  logic           mask_en,
  input  logic           mask_load,
  input  logic           mask_si
);
  import scw_pkg::*;

  logic           active;
  out_mode_e      mode;
  logic [NC-1:0]  mask_q;
  logic [NC-1:0]  masked;
  logic [NCH-1:0] xor_out;
  logic [NCH-1:0] tail;
  logic [MW-1:0]  misr_state;
  logic [NCH-1:0] so_next;

  assign active = comp_en & master_en;

  always_comb begin
    if (!active)      mode = OUT_BYPASS;
    else if (misr_sel) mode = OUT_MISR;
    else              mode = OUT_XOR;
  end

  scw_decomp #(.NCH(NCH), .RATIO(RATIO)) u_decomp (
    .active    (active),
    .spread_sel(spread_sel),
    .scan_in   (scan_in),
    .chain_so  (chain_so),
    .chain_si  (chain_si)
  );

  scw_mask #(.NC(NC)) u_mask (
    .mask_clk (mask_clk),
    .rst      (rst),
    .mask_en  (mask_en),
    .mask_load(mask_load),
    .mask_si  (mask_si),
    .mask_q   (mask_q)
  );

  scw_compact #(.NCH(NCH), .RATIO(RATIO)) u_compact (
    .chain_so(chain_so),
    .mask_q  (mask_q),
    .masked  (masked),
    .xor_out (xor_out)
  );

  scw_misr #(.NC(NC), .MW(MW), .POLY(POLY)) u_misr (
    .clk     (clk),
    .rst     (rst),
    .run     (active & misr_sel),
    .shift_en(shift_en),
    .unload  (misr_unload),
    .din     (masked),
    .state   (misr_state)
  );

  for (genvar l = 0; l < NCH; l++) begin : g_tail
    assign tail[l] = chain_so[(RATIO-1)*NCH + l];
  end

  always_comb begin
    so_next = '0;
    unique case (mode)
      OUT_BYPASS: so_next = tail;
      OUT_XOR:    so_next = xor_out;
      OUT_MISR:   so_next[0] = misr_unload & misr_state[MW-1];
      default:    so_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) scan_out <= '0;
    else     scan_out <= so_next;
  end
endmodule

// File: rtl/scw_checker.sv
module scw_checker #(
  parameter int NCH = 2,
  parameter int NC  = 4,
  parameter int MW  = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           shift_en,
  input logic           comp_en,
  input logic           master_en,
  input logic           spread_sel,
  input logic           misr_sel,
  input logic           misr_unload,
  input logic [NCH-1:0] scan_in,
  input logic [NCH-1:0] scan_out,
  input logic [NC-1:0]  chain_si,
  input logic [NC-1:0]  chain_so,
  input logic           mask_clk,
  input logic           mask_load,
  input logic [NC-1:0]  mask_q,
  input logic [MW-1:0]  misr_q
);
  AST_BYPASS_HEAD: assert property (@(posedge clk) disable iff (rst)
    !(comp_en && master_en) |-> chain_si[NCH-1:0] == scan_in); // R3

  AST_MASTER_GATE: assert property (@(posedge clk) disable iff (rst)
    (comp_en && !master_en) |-> chain_si[NCH] == chain_so[0]); // R2

  AST_BCAST_FANOUT: assert property (@(posedge clk) disable iff (rst)
    (comp_en && master_en && !spread_sel) |-> chain_si[NCH] == scan_in[0]); // R4

  AST_MISR_QUIET: assert property (@(posedge clk) disable iff (rst)
    (comp_en && master_en && misr_sel && !misr_unload) |=> scan_out == '0); // R9

  AST_UNLOAD_TOP: assert property (@(posedge clk) disable iff (rst)
    (comp_en && master_en && misr_sel && misr_unload) |=> scan_out[0] == $past(misr_q[MW-1])); // R11

  AST_MISR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !misr_unload) |=> $stable(misr_q)); // R12

  AST_MASK_HOLD: assert property (@(posedge mask_clk) disable iff (rst)
    !mask_load |=> $stable(mask_q)); // R8
endmodule

bind scan_comp_wrap scw_checker #(.NCH(NCH), .NC(NC), .MW(MW)) u_scw_checker (
  .clk        (clk),
  .rst        (rst),
  .shift_en   (shift_en),
  .comp_en    (comp_en),
  .master_en  (master_en),
  .spread_sel (spread_sel),
  .misr_sel   (misr_sel),
  .misr_unload(misr_unload),
  .scan_in    (scan_in),
  .scan_out   (scan_out),
  .chain_si   (chain_si),
  .chain_so   (chain_so),
  .mask_clk   (mask_clk),
  .mask_load  (mask_load),
  .mask_q     (mask_q),
  .misr_q     (misr_state)
);

// File: tb/scan_comp_wrap_bench.sv
module scan_comp_wrap_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 2;
  localparam int RATIO = 2;
  localparam int NC    = NCH * RATIO;
  localparam int MW    = 8;
  localparam logic [MW-1:0] POLY = 8'h1D;
  localparam int CL    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_en = 0, comp_en = 0, master_en = 0, spread_sel = 0;
  logic misr_sel = 0, misr_unload = 0;
  logic [NCH-1:0] scan_in = '0;
  logic [NCH-1:0] scan_out;
  logic [NC-1:0]  chain_si;
  logic [NC-1:0]  chain_so;
  logic mask_clk = 0, mask_en = 0, mask_load = 0, mask_si = 0;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  logic [NC-1:0] bm_shift = '0;
  logic [NC-1:0] bm_mask  = '0;
  logic [MW-1:0] bmisr    = '0;
  logic          bse_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_comp_wrap #(.NCH(NCH), .RATIO(RATIO), .MW(MW), .POLY(POLY)) u_scan_comp_wrap (
    .clk(clk), .rst(rst), .shift_en(shift_en), .comp_en(comp_en),
    .master_en(master_en), .spread_sel(spread_sel), .misr_sel(misr_sel),
    .misr_unload(misr_unload), .scan_in(scan_in), .scan_out(scan_out),
    .chain_si(chain_si), .chain_so(chain_so), .mask_clk(mask_clk),
    .mask_en(mask_en), .mask_load(mask_load), .mask_si(mask_si)
  );

  // Behavioural model of the internal chains
  logic [CL-1:0] chn [NC];
  always_ff @(posedge clk) begin
    for (int k = 0; k < NC; k++) begin
      if (rst)           chn[k] <= '0;
      else if (shift_en) chn[k] <= {chn[k][CL-2:0], chain_si[k]};
    end
  end
  always_comb for (int k = 0; k < NC; k++) chain_so[k] = chn[k][CL-1];

  function automatic logic [NC-1:0] exp_chain_si(logic act, logic spr,
      logic [NCH-1:0] si, logic [NC-1:0] cso);
    logic [NC-1:0] r;
    for (int k = 0; k < NC; k++) begin
      int l = k % NCH;
      int g = k / NCH;
      if (!act)        r[k] = (g == 0) ? si[l] : cso[k-NCH];
      else if (!spr)   r[k] = si[l];
      else if (g == 0) r[k] = si[l];
      else             r[k] = si[l] ^ si[(l + 1 + ((g-1) % (NCH-1))) % NCH];
    end
    return r;
  endfunction

  task automatic check(string tag, string what, logic [NC-1:0] got, logic [NC-1:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
    end
  endtask

  // One clock step: drive, check decompressor, predict and check scan_out
  task automatic step(string tag, logic se, logic ce, logic me, logic spr,
                      logic ms, logic ul, logic [NCH-1:0] si);
    logic act;
    logic [NCH-1:0] exp_so;
    logic [NC-1:0] msk;
    logic [MW-1:0] fold, nxt;
    shift_en = se; comp_en = ce; master_en = me; spread_sel = spr;
    misr_sel = ms; misr_unload = ul; scan_in = si;
    #1;
    act = ce & me;
    check(tag, act ? (spr ? "R5 spread" : "R4 broadcast") : "R3 bypass chain_si",
          chain_si, exp_chain_si(act, spr, si, chain_so));
    msk = chain_so & ~bm_mask;
    fold = '0;
    for (int k = 0; k < NC; k++) fold[k % MW] ^= msk[k];
    nxt = bmisr;
    exp_so = '0;
    if (!act) begin
      for (int l = 0; l < NCH; l++) exp_so[l] = chain_so[(RATIO-1)*NCH + l];
    end else if (ms) begin
      if (ul) begin
        exp_so[0] = bmisr[MW-1];
        nxt = bmisr << 1;
      end else if (se) begin
        nxt = (bse_prev ? (({bmisr[MW-2:0], 1'b0}) ^ (bmisr[MW-1] ? POLY : '0)) : '0) ^ fold;
      end
    end else begin
      for (int l = 0; l < NCH; l++)
        for (int g = 0; g < RATIO; g++) exp_so[l] ^= msk[g*NCH + l];
    end
    @(posedge clk);
    #1;
    bmisr = nxt;
    bse_prev = se;
    check(tag, !act ? "R3 bypass scan_out" : (ms ? (ul ? "R11 unload" : "R9 misr quiet")
          : "R6 xor tree"), NC'(scan_out), NC'(exp_so));
  endtask

  task automatic mpulse(logic en, logic ld, logic b);
    mask_en = en; mask_load = ld; mask_si = b;
    #1 mask_clk = 1;
    if (!rst) begin
      if (ld) bm_mask = bm_shift;
      if (en) bm_shift = {bm_shift[NC-2:0], b};
    end
    #1 mask_clk = 0;
    mask_en = 0; mask_load = 0;
  endtask

  // R8: shift NC bits (value bit NC-1 first) then optionally load
  task automatic load_mask(logic [NC-1:0] m, logic do_load);
    for (int i = NC-1; i >= 0; i--) mpulse(1'b1, 1'b0, m[i]);
    if (do_load) mpulse(1'b0, 1'b1, 1'b0);
  endtask

  task automatic rand_steps(string tag, int n, logic ce, logic me, logic spr, logic ms);
    for (int i = 0; i < n; i++)
      step(tag, 1'b1, ce, me, spr, ms, 1'b0, NCH'($urandom));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5C0A_11E5));
    repeat (3) @(posedge clk);
    mpulse(1'b0, 1'b0, 1'b0);
    mpulse(1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 0;
    @(posedge clk); #1;
    check("R1", "reset scan_out", NC'(scan_out), '0);

    // R3 and R2: bypass with either enable low
    rand_steps("R3", 20, 1'b0, 1'b0, 1'b0, 1'b0);
    rand_steps("R2 comp_en only", 20, 1'b1, 1'b0, 1'b1, 1'b0);
    rand_steps("R2 master only", 12, 1'b0, 1'b1, 1'b1, 1'b1);

    // R4 / R5 / R6 without mask
    rand_steps("R4", 24, 1'b1, 1'b1, 1'b0, 1'b0);
    rand_steps("R5", 24, 1'b1, 1'b1, 1'b1, 1'b0);
    for (int p = 0; p < (1 << NCH); p++)
      step("R5 directed", 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, NCH'(p));

    // R7 / R8: masks, including a shift without load that must not apply
    step("R8 idle", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    load_mask(NC'(4'b0101), 1'b1);
    rand_steps("R7 mask 0101", 16, 1'b1, 1'b1, 1'b0, 1'b0);
    step("R8 idle", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    load_mask(NC'(4'b1010), 1'b0);
    rand_steps("R8 no load", 16, 1'b1, 1'b1, 1'b1, 1'b0);
    step("R8 idle", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    mpulse(1'b0, 1'b1, 1'b0);
    rand_steps("R8 loaded 1010", 16, 1'b1, 1'b1, 1'b0, 1'b0);
    rand_steps("R7 bypass ignores mask", 12, 1'b0, 1'b0, 1'b0, 1'b0);

    // R9 / R10 / R12 / R11: MISR with a mask in place
    step("R10 idle", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0);
    rand_steps("R9", 14, 1'b1, 1'b1, 1'b1, 1'b1);
    step("R12 hold", 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, NCH'($urandom));
    step("R12 hold", 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, NCH'($urandom));
    rand_steps("R10 restart", 9, 1'b1, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < MW + 1; i++)
      step("R11", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, '0);

    // Unmasked MISR window then unload while shift_en stays high
    step("R7 idle", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    load_mask('0, 1'b1);
    rand_steps("R9 unmasked", 20, 1'b1, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < MW; i++)
      step("R11 priority", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, NCH'($urandom));
    rand_steps("R6 final", 16, 1'b1, 1'b1, 1'b1, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule